// File: doc/BRIEF.md
# Dual-Slope Centre-Aligned PWM Timer

This block is an up/down timer that produces symmetric pulse-width-modulated waveforms on two compare channels, A and B. The counter climbs from zero to a ceiling, turns round, and descends to zero again. Each channel compares the running count with its own threshold. It drives its output one way when the match happens on the rising slope and the other way when it happens on the falling slope. The resulting pulses are always centred on the zero point of the count, which makes the block suited to motor and power-stage drive, where edges on several phases must stay aligned.

The ceiling is either the full count range (255 with the default width) or the active threshold of channel A. Threshold writes land in a pending register. They become active only when the counter is at its ceiling, so a period never mixes two thresholds. All state moves only on clock edges where the tick enable from an external prescaler is high. A synchronous reset returns everything to zero, with the count direction set to up.

Top module: `sym_pwm_timer`

## Requirements
- R1: While `tick_en` is high, the count steps 0,1,…,TOP,TOP−1,…,1,0,1,… It shows TOP for exactly one tick and 0 for exactly one tick, so one period is 2·TOP ticks (510 ticks when TOP is 255).
- R2: With `top_from_a` = 0, TOP is the all-ones count (255). With `top_from_a` = 1, TOP is channel A's active threshold.
- R3: A strobe on `cmp_a_wr`/`cmp_b_wr` stores the value in a pending register. The channel's active threshold takes the pending value only on a tick where the count is at TOP, so the waveform keeps using the old threshold until then.
- R4: Output mode 2 (clear-on-rise) drives the output low after a match on the rising slope and high after a match on the falling slope. With threshold C, the output is high for 2·C ticks per period, split equally between the falling and the rising slope.
- R5: Output mode 3 (set-on-rise) is the complement of mode 2: high for 2·(TOP−C) ticks per period.
- R6: A match at count 0 counts as rising and a match at TOP counts as falling. So C = 0 gives a constant low and C = TOP a constant high in mode 2, and the reverse in mode 3.
- R7: Output mode 0 holds the output low. Mode 1 toggles channel A on each match only when `top_from_a` = 1, and holds it low otherwise. Mode 1 holds channel B low.
- R8: `match_a_o`/`match_b_o` pulse high for one clock after a tick on which the count equals that channel's active threshold. This happens twice per period, or once when the threshold is 0 or TOP. The pulses are independent of the output mode.
- R9: `bottom_o` pulses high for one clock after each tick on which the count is 0, once per period.
- R10: While `tick_en` is low, the count and the outputs hold, and no flag pulses.
- R11: While `rst` is high, the count is 0, both outputs are low and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaler tick; state advances only when high |
| top_from_a | input | 1 | 0: TOP is all ones; 1: TOP is channel A's active threshold |
| cmp_a_wr | input | 1 | Write strobe for channel A's pending threshold |
| cmp_a_val | input | W | Threshold value for channel A |
| cmp_b_wr | input | 1 | Write strobe for channel B's pending threshold |
| cmp_b_val | input | W | Threshold value for channel B |
| mode_a | input | 2 | Channel A output mode (0 off, 1 toggle, 2 clear-on-rise, 3 set-on-rise) |
| mode_b | input | 2 | Channel B output mode (same encoding; 1 behaves as off) |
| count_o | output | W | Current count |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| match_a_o | output | 1 | Channel A match pulse |
| match_b_o | output | 1 | Channel B match pulse |
| bottom_o | output | 1 | Count-at-zero pulse |

## Verification
The hardest case to reach from the ports is a threshold write that arrives halfway up a slope. There, the pending and the active threshold differ while the count sits between them. The stimulus waits until the count output shows a known value on the rising slope and writes a new threshold at that moment. It then probes the waveform at points where the old and the new threshold predict opposite levels, both before the turn at TOP and after it. The toggle mode is reached only by also taking the ceiling from channel A, with a period that is measured from the count itself.

// File: rtl/sym_pwm_pkg.sv
package sym_pwm_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLR_UP = 2'd2,
        OM_SET_UP = 2'd3
    } out_mode_e;

endpackage

// File: rtl/sym_pwm_counter.sv
module sym_pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt_o,
    output logic         slope_up_o,
    output logic         at_top_o
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        at_top_o   = (s_q.cnt >= top);
        // end points decide the slope: zero is rising, the ceiling is falling
        if (s_q.cnt == ZERO)  slope_up_o = 1'b1;
        else if (at_top_o)    slope_up_o = 1'b0;
        else                  slope_up_o = s_q.up;

        if (en) begin
            if (s_q.cnt == ZERO) begin
                s_d.cnt = (top == ZERO) ? ZERO : ONE;
                s_d.up  = 1'b1;
            end else if (at_top_o) begin
                s_d.cnt = s_q.cnt - ONE;
                s_d.up  = 1'b0;
            end else begin
                s_d.cnt = s_q.up ? (s_q.cnt + ONE) : (s_q.cnt - ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt <= ZERO;
            s_q.up  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/sym_pwm_cmp_bank.sv
module sym_pwm_cmp_bank #(
    parameter int W   = 8,
    parameter int NCH = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          wr,
    input  logic [NCH-1:0][W-1:0]   wr_val,
    input  logic                    load,
    output logic [NCH-1:0][W-1:0]   act_o
);
    typedef struct packed {
        logic [NCH-1:0][W-1:0] pend;
        logic [NCH-1:0][W-1:0] act;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NCH; i++) begin
            if (wr[i])  s_d.pend[i] = wr_val[i];
            if (load)   s_d.act[i]  = s_q.pend[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign act_o = s_q.act;

endmodule

// File: rtl/sym_pwm_channel.sv
module sym_pwm_channel
    import sym_pwm_pkg::*;
#(
    parameter int W            = 8,
    parameter bit ALLOW_TOGGLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic         slope_up,
    input  logic [W-1:0] cmp,
    input  out_mode_e    mode,
    input  logic         toggle_ok,
    output logic         wave_o,
    output logic         match_o
);
    typedef struct packed {
        logic oc;
        logic hit;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   hit_now;
    logic   tog_live;

    assign hit_now  = (cnt == cmp);
    assign tog_live = ALLOW_TOGGLE && toggle_ok;

    always_comb begin
        s_d     = s_q;
        s_d.hit = en && hit_now;
        if (en && hit_now) begin
            case (mode)
                OM_OFF:    s_d.oc = s_q.oc;
                OM_TOGGLE: s_d.oc = tog_live ? ~s_q.oc : s_q.oc;
                OM_CLR_UP: s_d.oc = ~slope_up;
                OM_SET_UP: s_d.oc = slope_up;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        case (mode)
            OM_OFF:    wave_o = 1'b0;
            OM_TOGGLE: wave_o = tog_live ? s_q.oc : 1'b0;
            default:   wave_o = s_q.oc;
        endcase
    end

    assign match_o = s_q.hit;

endmodule

// File: rtl/sym_pwm_timer.sv
module sym_pwm_timer
    import sym_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         top_from_a,
    input  logic         cmp_a_wr,
    input  logic [W-1:0] cmp_a_val,
    input  logic         cmp_b_wr,
    input  logic [W-1:0] cmp_b_val,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    output logic [W-1:0] count_o,
    output logic         wave_a_o,
    output logic         wave_b_o,
    output logic         match_a_o,
    output logic         match_b_o,
    output logic         bottom_o
);
    localparam logic [W-1:0] FULL = '1;
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic bot;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [NCH-1:0]        wr_v;
    logic [NCH-1:0][W-1:0] val_v;
    logic [NCH-1:0][W-1:0] act_v;
    out_mode_e             mode_v [NCH];
    logic [NCH-1:0]        wave_v;
    logic [NCH-1:0]        match_v;
    logic [W-1:0]          top_val;
    logic                  slope_up;
    logic                  at_top;

    assign wr_v      = {cmp_b_wr, cmp_a_wr};
    assign val_v     = {cmp_b_val, cmp_a_val};
    assign mode_v[0] = out_mode_e'(mode_a);
    assign mode_v[1] = out_mode_e'(mode_b);
    assign top_val   = top_from_a ? act_v[0] : FULL;

    sym_pwm_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en         (tick_en),
        .top        (top_val),
        .cnt_o      (count_o),
        .slope_up_o (slope_up),
        .at_top_o   (at_top)
    );

    sym_pwm_cmp_bank #(.W(W), .NCH(NCH)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_v),
        .wr_val (val_v),
        .load   (tick_en && at_top),
        .act_o  (act_v)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        sym_pwm_channel #(.W(W), .ALLOW_TOGGLE(i == 0)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .en        (tick_en),
            .cnt       (count_o),
            .slope_up  (slope_up),
            .cmp       (act_v[i]),
            .mode      (mode_v[i]),
            .toggle_ok (top_from_a),
            .wave_o    (wave_v[i]),
            .match_o   (match_v[i])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.bot = tick_en && (count_o == ZERO);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign wave_a_o  = wave_v[0];
    assign wave_b_o  = wave_v[1];
    assign match_a_o = match_v[0];
    assign match_b_o = match_v[1];
    assign bottom_o  = s_q.bot;

endmodule

// File: rtl/sym_pwm_timer_chk.sv
module sym_pwm_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [W-1:0] cnt_o,
    input logic [1:0]   mode_a,
    input logic [1:0]   mode_b,
    input logic         wave_a,
    input logic         wave_b,
    input logic         match_a,
    input logic         match_b,
    input logic         ovf
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt_o == $past(cnt_o) + ONE) || (cnt_o == $past(cnt_o) - ONE) ||
               (cnt_o == ZERO && $past(cnt_o) == ZERO));

    assert_fall_rising_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'd2 && $past(mode_a) == 2'd2 && $fell(wave_a) && cnt_o != ZERO)
        |-> cnt_o == $past(cnt_o) + ONE);

    assert_rise_rising_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'd3 && $past(mode_a) == 2'd3 && $rose(wave_a) && cnt_o != ZERO)
        |-> cnt_o == $past(cnt_o) + ONE);

    assert_off_low_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'd0 || mode_b == 2'd0 || mode_b == 2'd1)
        |-> ((mode_a != 2'd0 || !wave_a) && (mode_b > 2'd1 || !wave_b)));

    assert_match_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (match_a || match_b) |-> $past(en));

    assert_bottom_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ovf |-> ($past(cnt_o) == ZERO && $past(en)));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cnt_o) && !ovf && !match_a && !match_b));

endmodule

bind sym_pwm_timer sym_pwm_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (tick_en),
    .cnt_o   (count_o),
    .mode_a  (mode_a),
    .mode_b  (mode_b),
    .wave_a  (wave_a_o),
    .wave_b  (wave_b_o),
    .match_a (match_a_o),
    .match_b (match_b_o),
    .ovf     (bottom_o)
);

// File: tb/tb_sym_pwm_timer.sv
module tb_sym_pwm_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       top_from_a = 1'b0;
    logic       cmp_a_wr = 1'b0;
    logic [7:0] cmp_a_val = '0;
    logic       cmp_b_wr = 1'b0;
    logic [7:0] cmp_b_val = '0;
    logic [1:0] mode_a = '0;
    logic [1:0] mode_b = '0;
    logic [7:0] count_o;
    logic       wave_a_o, wave_b_o, match_a_o, match_b_o, bottom_o;

    always #4 clk = ~clk;

    sym_pwm_timer #(.W(8)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .top_from_a(top_from_a),
        .cmp_a_wr(cmp_a_wr), .cmp_a_val(cmp_a_val),
        .cmp_b_wr(cmp_b_wr), .cmp_b_val(cmp_b_val),
        .mode_a(mode_a), .mode_b(mode_b),
        .count_o(count_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o),
        .match_a_o(match_a_o), .match_b_o(match_b_o), .bottom_o(bottom_o)
    );

    typedef struct packed {
        logic       sel;
        logic [1:0] ma;
        logic [1:0] mb;
        logic [7:0] ca;
        logic [7:0] cb;
        logic [9:0] hi_a;   // 1023: not checked
        logic [9:0] hi_b;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 2'd3, 8'd100, 8'd50,  10'd200,  10'd410},
        '{1'b0, 2'd2, 2'd2, 8'd0,   8'd255, 10'd0,    10'd510},
        '{1'b0, 2'd3, 2'd3, 8'd0,   8'd255, 10'd510,  10'd0},
        '{1'b0, 2'd1, 2'd0, 8'd10,  8'd20,  10'd0,    10'd0},
        '{1'b1, 2'd1, 2'd2, 8'd100, 8'd40,  10'd1023, 10'd80},
        '{1'b1, 2'd2, 2'd3, 8'd60,  8'd20,  10'd120,  10'd80}
    };

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int cur_cnt = 0, prev_cnt = 0;
    int cur_wa = 0, prev_wa = 0, cur_wb = 0, prev_wb = 0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        prev_cnt = cur_cnt;  cur_cnt = int'(count_o);
        prev_wa  = cur_wa;   cur_wa  = int'(wave_a_o);
        prev_wb  = cur_wb;   cur_wb  = int'(wave_b_o);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick_en = 1'b1;
        repeat (2) step();
        rst = 1'b0;
    endtask

    task automatic write_cmp(input int a, input int b);
        cmp_a_val = 8'(a); cmp_b_val = 8'(b);
        cmp_a_wr = 1'b1;   cmp_b_wr = 1'b1;
        step();
        cmp_a_wr = 1'b0;   cmp_b_wr = 1'b0;
    endtask

    task automatic wait_for(input int v, input bit up);
        do step(); while (!(cur_cnt == v && ((cur_cnt > prev_cnt) == up)));
    endtask

    function automatic string hi_tag(input int m, input int c, input int top);
        if (m < 2) return "R7";
        if (c == 0 || c == top) return "R6";
        return (m == 2) ? "R4" : "R5";
    endfunction

    task automatic run_vec(input vec_t v);
        int top, per, hia, hib, upa, dna, upb, dnb, ea, eb, ma, mb, ov, zr;
        int exp_ea, exp_eb;
        top = v.sel ? int'(v.ca) : 255;
        per = 2 * top;
        top_from_a = v.sel;
        mode_a = v.ma;
        mode_b = v.mb;
        do_reset();
        write_cmp(int'(v.ca), int'(v.cb));
        repeat (3 * per + 10) step();
        while (cur_cnt != 0) step();
        hia = 0; hib = 0; upa = 0; dna = 0; upb = 0; dnb = 0;
        ea = 0; eb = 0; ma = 0; mb = 0; ov = 0; zr = 0;
        for (int i = 0; i < per; i++) begin
            hia += cur_wa;  hib += cur_wb;
            if (cur_cnt > prev_cnt) begin upa += cur_wa; upb += cur_wb; end
            else                    begin dna += cur_wa; dnb += cur_wb; end
            ea += (cur_wa != prev_wa) ? 1 : 0;
            eb += (cur_wb != prev_wb) ? 1 : 0;
            ma += int'(match_a_o);
            mb += int'(match_b_o);
            ov += int'(bottom_o);
            zr += (cur_cnt == 0) ? 1 : 0;
            step();
        end
        // R1/R2: back at zero after exactly 2*TOP samples, zero seen once
        check(v.sel ? "R2 period" : "R1 period", cur_cnt, 0);
        check("R1 single bottom", zr, 1);
        if (int'(v.hi_a) != 1023) begin
            check(hi_tag(v.ma, v.ca, top), hia, int'(v.hi_a));
            check("R4 symmetry A", upa, dna);
        end
        check(hi_tag(v.mb, v.cb, top), hib, int'(v.hi_b));
        check("R4 symmetry B", upb, dnb);
        if (v.ma == 2'd1) exp_ea = v.sel ? 1 : 0;
        else exp_ea = (v.hi_a == 0 || int'(v.hi_a) == per) ? 0 : 2;
        if (v.mb <= 2'd1) exp_eb = 0;
        else exp_eb = (v.hi_b == 0 || int'(v.hi_b) == per) ? 0 : 2;
        check(v.ma == 2'd1 ? "R7 edges A" : "R4 edges A", ea, exp_ea);
        check(v.mb <= 2'd1 ? "R7 edges B" : "R4 edges B", eb, exp_eb);
        check("R8 match A", ma, (v.ca == 0 || int'(v.ca) == top) ? 1 : 2);
        check("R8 match B", mb, (v.cb == 0 || int'(v.cb) == top) ? 1 : 2);
        check("R9 bottom", ov, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0, flags, moved;
        // R11: reset state
        rst = 1'b1;
        step();
        check("R11 count", int'(count_o), 0);
        check("R11 wave A", int'(wave_a_o), 0);
        check("R11 wave B", int'(wave_b_o), 0);
        check("R11 flags", int'(match_a_o) + int'(match_b_o), 0);
        check("R11 bottom", int'(bottom_o), 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R3: mid-slope threshold change takes effect only after TOP
        top_from_a = 1'b0; mode_a = 2'd2; mode_b = 2'd0;
        do_reset();
        write_cmp(100, 0);
        repeat (600) step();
        wait_for(50, 1'b1);
        write_cmp(200, 0);
        wait_for(150, 1'b1);
        check("R3 old threshold kept", cur_wa, 0);
        wait_for(199, 1'b0);
        check("R3 new threshold falling", cur_wa, 1);
        wait_for(150, 1'b0);
        check("R3 new threshold at 150", cur_wa, 1);
        wait_for(201, 1'b1);
        check("R3 new threshold rising", cur_wa, 0);

        // R10: tick enable low freezes everything
        tick_en = 1'b0;
        c0 = cur_cnt;
        flags = 0; moved = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            flags += int'(match_a_o) + int'(match_b_o) + int'(bottom_o);
            moved += (cur_cnt != c0) ? 1 : 0;
        end
        check("R10 count held", moved, 0);
        check("R10 no flags", flags, 0);
        tick_en = 1'b1;
        step();
        check("R10 resumes", (cur_cnt != c0) ? 1 : 0, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule